// File: doc/BRIEF.md
# Raster Target Counter with Kernel Walk

This block sequences the addresses for a resampling or filtering engine. It holds a destination pixel position (u, v) that scans a programmable rectangle one line at a time. For every destination pixel it first steps an offset pair through a programmable neighbourhood of up to 16 by 16 source points. On each of those steps it strobes an accumulate output, so that an external multiply-accumulate unit can sum weighted source pixels. Once the neighbourhood is exhausted, it issues one write strobe carrying the destination address. It then moves one pixel along the line.

An external controller drives the block with a 4-bit command each clock:
- 0: hold
- 1: initialize
- 2: skip to the next line
- 3: step

All other codes act as hold. The memories, coefficient tables and arithmetic sit outside the block. The outputs are decoded from the current command and state within the same cycle. The counters update on the rising clock edge.

Top module: `rtc_top`

## Requirements
- R1: After reset the block is idle: done=1, tgt_u=0, tgt_v=0, off_x=0, off_y=0, and accum, acc_clr and tgt_we are low while the command is 0.
- R2: Command 1 (initialize) loads tgt_u=umin, tgt_v=vmin and offsets 0, selects the neighbourhood phase and clears done, at the next edge.
- R3: In the neighbourhood phase, each command 3 asserts accum for the present offset (off_x, off_y). off_x runs fastest from 0 to walk_w-1, then off_y increases, up to walk_h-1. walk_w and walk_h take values from 1 to 16.
- R4: acc_clr is asserted together with accum on the first step of each neighbourhood (offset 0,0) and at no other time.
- R5: The command 3 after the last neighbourhood step asserts tgt_we, without accum, with tgt_u/tgt_v still showing the pixel being finished. This happens once per destination pixel.
- R6: After a write, tgt_u increases by one. If tgt_u was umax, it returns to umin and tgt_v increases by one.
- R7: end_row is high whenever tgt_u equals umax. at_limit is high whenever tgt_u equals umax and tgt_v equals vmax.
- R8: The write of the pixel at (umax, vmax) sets done. While done is set, commands 2 and 3 produce no strobes and change no counter. Only command 1 clears done.
- R9: Command 0 and the unused codes 4 to 15 hold every counter and done, and keep all strobes low.
- R10: Command 2 abandons the present pixel: tgt_u=umin, tgt_v increases by one and offsets return to 0. If tgt_v equals vmax, it sets done instead.
- R11: With walk_w=walk_h=1, each pixel takes two steps: one accumulate with clear, then one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 4 | Command: 0 hold, 1 initialize, 2 next line, 3 step |
| umin | input | 12 | First u of each line |
| umax | input | 12 | Last u of each line |
| vmin | input | 12 | First line |
| vmax | input | 12 | Last line |
| walk_w | input | 5 | Neighbourhood width, 1..16 |
| walk_h | input | 5 | Neighbourhood height, 1..16 |
| tgt_u | output | 12 | Destination u address |
| tgt_v | output | 12 | Destination v address |
| off_x | output | 4 | Neighbourhood x offset |
| off_y | output | 4 | Neighbourhood y offset |
| accum | output | 1 | Accumulate strobe for this step |
| acc_clr | output | 1 | Clear the accumulator (first step of a neighbourhood) |
| tgt_we | output | 1 | Destination write strobe |
| end_row | output | 1 | tgt_u is at umax |
| at_limit | output | 1 | tgt_u at umax and tgt_v at vmax |
| done | output | 1 | Whole rectangle written |

## Verification
The properties take for granted that the rectangle bounds and neighbourhood sizes are legal: umin<=umax, vmin<=vmax, and sizes from 1 to 16. They also assume these inputs stay constant between an initialize and the next. The bench therefore changes umin, umax, vmin, vmax, walk_w and walk_h only while the command is hold, and always follows such a change with an initialize. It never drives a size of 0 or above 16. Within those limits, the table run and the directed runs cover line wrap, the final pixel, skipping to the next line, and both neighbourhood extremes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [3:0] OP_NOOP = 4'h0;
  localparam logic [3:0] OP_INIT = 4'h1;
  localparam logic [3:0] OP_NEXT = 4'h2;
  localparam logic [3:0] OP_STEP = 4'h3;

  typedef enum logic {PH_WALK = 1'b0, PH_WRITE = 1'b1} phase_e;
endpackage

// File: rtl/rtc_walk.sv
module rtc_walk #(
  parameter int KW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [KW:0]   size_w,
  input  logic [KW:0]   size_h,
  output logic [KW-1:0] dx,
  output logic [KW-1:0] dy,
  output logic          first,
  output logic          last
);
  // true when an offset is the final index of a dimension of size sz
  function automatic logic at_end(input logic [KW-1:0] cur, input logic [KW:0] sz);
    return ({1'b0, cur} == (sz - 1'b1));
  endfunction

  logic x_end;
  assign x_end = at_end(dx, size_w);
  assign first = (dx == '0) && (dy == '0);
  assign last  = x_end && at_end(dy, size_h);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dx <= '0;
      dy <= '0;
    end else if (clr || (adv && last)) begin
      dx <= '0;
      dy <= '0;
    end else if (adv) begin
      if (x_end) begin
        dx <= '0;
        dy <= dy + 1'b1;
      end else begin
        dx <= dx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_raster.sv
module rtc_raster #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic          jump,
  input  logic [AW-1:0] umin,
  input  logic [AW-1:0] umax,
  input  logic [AW-1:0] vmin,
  input  logic [AW-1:0] vmax,
  output logic [AW-1:0] u,
  output logic [AW-1:0] v,
  output logic          row_end,
  output logic          at_lim,
  output logic          fin
);
  function automatic logic [AW-1:0] bump(input logic [AW-1:0] x);
    return x + 1'b1;
  endfunction

  assign row_end = (u == umax);
  assign at_lim  = row_end && (v == vmax);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u   <= '0;
      v   <= '0;
      fin <= 1'b1;
    end else if (load) begin
      u   <= umin;
      v   <= vmin;
      fin <= 1'b0;
    end else if (!fin) begin
      if (adv) begin
        if (at_lim) begin
          fin <= 1'b1;
        end else if (row_end) begin
          u <= umin;
          v <= bump(v);
        end else begin
          u <= bump(u);
        end
      end else if (jump) begin
        if (v == vmax) begin
          fin <= 1'b1;
        end else begin
          u <= umin;
          v <= bump(v);
        end
      end
    end
  end
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] instr,
  input  logic       fin,
  input  logic       walk_first,
  input  logic       walk_last,
  output logic       walk_clr,
  output logic       walk_adv,
  output logic       ras_load,
  output logic       ras_adv,
  output logic       ras_jump,
  output logic       accum,
  output logic       acc_clr,
  output logic       tgt_we
);
  phase_e phase;
  logic   step_ok;

  assign step_ok = (instr == OP_STEP) && !fin;

  always_comb begin
    ras_load = (instr == OP_INIT);
    ras_jump = (instr == OP_NEXT) && !fin;
    walk_clr = ras_load || ras_jump;
    accum    = step_ok && (phase == PH_WALK);
    acc_clr  = accum && walk_first;
    walk_adv = accum;
    tgt_we   = step_ok && (phase == PH_WRITE);
    ras_adv  = tgt_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_WALK;
    end else if (ras_load || ras_jump) begin
      phase <= PH_WALK;
    end else if (step_ok) begin
      if (phase == PH_WALK) begin
        if (walk_last) phase <= PH_WRITE;
      end else begin
        phase <= PH_WALK;
      end
    end
  end
endmodule

// File: rtl/rtc_top.sv
module rtc_top #(
  parameter int AW = 12,
  parameter int KW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    instr,
  input  logic [AW-1:0] umin,
  input  logic [AW-1:0] umax,
  input  logic [AW-1:0] vmin,
  input  logic [AW-1:0] vmax,
  input  logic [KW:0]   walk_w,
  input  logic [KW:0]   walk_h,
  output logic [AW-1:0] tgt_u,
  output logic [AW-1:0] tgt_v,
  output logic [KW-1:0] off_x,
  output logic [KW-1:0] off_y,
  output logic          accum,
  output logic          acc_clr,
  output logic          tgt_we,
  output logic          end_row,
  output logic          at_limit,
  output logic          done
);
  logic walk_first, walk_last, walk_clr, walk_adv;
  logic ras_load, ras_adv, ras_jump;

  rtc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .instr(instr), .fin(done),
    .walk_first(walk_first), .walk_last(walk_last),
    .walk_clr(walk_clr), .walk_adv(walk_adv),
    .ras_load(ras_load), .ras_adv(ras_adv), .ras_jump(ras_jump),
    .accum(accum), .acc_clr(acc_clr), .tgt_we(tgt_we)
  );

  rtc_walk #(.KW(KW)) u_walk (
    .clk(clk), .rst_n(rst_n), .clr(walk_clr), .adv(walk_adv),
    .size_w(walk_w), .size_h(walk_h),
    .dx(off_x), .dy(off_y), .first(walk_first), .last(walk_last)
  );

  rtc_raster #(.AW(AW)) u_raster (
    .clk(clk), .rst_n(rst_n), .load(ras_load), .adv(ras_adv), .jump(ras_jump),
    .umin(umin), .umax(umax), .vmin(vmin), .vmax(vmax),
    .u(tgt_u), .v(tgt_v), .row_end(end_row), .at_lim(at_limit), .fin(done)
  );
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk
  import rtc_pkg::*;
#(
  parameter int AW = 12,
  parameter int KW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    instr,
  input logic [AW-1:0] umin,
  input logic [AW-1:0] vmin,
  input logic [KW:0]   walk_w,
  input logic [KW:0]   walk_h,
  input logic [AW-1:0] tgt_u,
  input logic [AW-1:0] tgt_v,
  input logic [KW-1:0] off_x,
  input logic [KW-1:0] off_y,
  input logic          accum,
  input logic          acc_clr,
  input logic          tgt_we,
  input logic          end_row,
  input logic          at_limit,
  input logic          done,
  input logic          walk_last
);
  // R4
  clr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |-> accum && off_x == '0 && off_y == '0);

  // R5
  we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accum && tgt_we));

  // R5
  last_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accum && walk_last && instr == OP_STEP |=> !accum);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !accum && !tgt_we);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && instr != OP_INIT |=> done);

  // R6
  u_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_we && !end_row |=> tgt_u == $past(tgt_u) + 1'b1 && $stable(tgt_v));

  // R6
  u_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_we && end_row && !at_limit |=> tgt_u == $past(umin) && tgt_v == $past(tgt_v) + 1'b1);

  // R9
  noop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr == OP_NOOP |=> $stable(tgt_u) && $stable(tgt_v) && $stable(off_x)
                         && $stable(off_y) && $stable(done));

  // R2
  init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr == OP_INIT |=> tgt_u == $past(umin) && tgt_v == $past(vmin) && !done
                         && off_x == '0 && off_y == '0);

  // R3
  off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accum |-> ({1'b0, off_x} < walk_w) && ({1'b0, off_y} < walk_h));
endmodule

bind rtc_top rtc_chk #(.AW(AW), .KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr(instr), .umin(umin), .vmin(vmin),
  .walk_w(walk_w), .walk_h(walk_h), .tgt_u(tgt_u), .tgt_v(tgt_v),
  .off_x(off_x), .off_y(off_y), .accum(accum), .acc_clr(acc_clr),
  .tgt_we(tgt_we), .end_row(end_row), .at_limit(at_limit), .done(done),
  .walk_last(walk_last)
);

// File: tb/rtc_top_bench.sv
module rtc_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  instr = 4'h0;
  logic [11:0] umin = '0, umax = '0, vmin = '0, vmax = '0;
  logic [4:0]  walk_w = 5'd1, walk_h = 5'd1;
  logic [11:0] tgt_u, tgt_v;
  logic [3:0]  off_x, off_y;
  logic        accum, acc_clr, tgt_we, end_row, at_limit, done;

  int checks = 0;
  int errs = 0;

  always #5 clk = ~clk;

  rtc_top u_rtc_top (
    .clk(clk), .rst_n(rst_n), .instr(instr), .umin(umin), .umax(umax),
    .vmin(vmin), .vmax(vmax), .walk_w(walk_w), .walk_h(walk_h),
    .tgt_u(tgt_u), .tgt_v(tgt_v), .off_x(off_x), .off_y(off_y),
    .accum(accum), .acc_clr(acc_clr), .tgt_we(tgt_we), .end_row(end_row),
    .at_limit(at_limit), .done(done)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic        acc;
    logic        clr;
    logic        we;
    logic [11:0] u;
    logic [11:0] v;
    logic [3:0]  dx;
    logic        eor;
    logic        dn;
  } vec_t;

  // region u 3..4, v 7..8, walk 2x1; strobes during the command, state after the edge
  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{4'd1, 1'b0, 1'b0, 1'b0, 12'd3, 12'd7, 4'd0, 1'b0, 1'b0},
    '{4'd3, 1'b1, 1'b1, 1'b0, 12'd3, 12'd7, 4'd1, 1'b0, 1'b0},
    '{4'd3, 1'b1, 1'b0, 1'b0, 12'd3, 12'd7, 4'd0, 1'b0, 1'b0},
    '{4'd3, 1'b0, 1'b0, 1'b1, 12'd4, 12'd7, 4'd0, 1'b1, 1'b0},
    '{4'd0, 1'b0, 1'b0, 1'b0, 12'd4, 12'd7, 4'd0, 1'b1, 1'b0},
    '{4'd3, 1'b1, 1'b1, 1'b0, 12'd4, 12'd7, 4'd1, 1'b1, 1'b0},
    '{4'd3, 1'b1, 1'b0, 1'b0, 12'd4, 12'd7, 4'd0, 1'b1, 1'b0},
    '{4'd3, 1'b0, 1'b0, 1'b1, 12'd3, 12'd8, 4'd0, 1'b0, 1'b0},
    '{4'd3, 1'b1, 1'b1, 1'b0, 12'd3, 12'd8, 4'd1, 1'b0, 1'b0},
    '{4'd3, 1'b1, 1'b0, 1'b0, 12'd3, 12'd8, 4'd0, 1'b0, 1'b0},
    '{4'd3, 1'b0, 1'b0, 1'b1, 12'd4, 12'd8, 4'd0, 1'b1, 1'b0},
    '{4'd7, 1'b0, 1'b0, 1'b0, 12'd4, 12'd8, 4'd0, 1'b1, 1'b0},
    '{4'd3, 1'b1, 1'b1, 1'b0, 12'd4, 12'd8, 4'd1, 1'b1, 1'b0},
    '{4'd3, 1'b1, 1'b0, 1'b0, 12'd4, 12'd8, 4'd0, 1'b1, 1'b0},
    '{4'd3, 1'b0, 1'b0, 1'b1, 12'd4, 12'd8, 4'd0, 1'b1, 1'b1},
    '{4'd3, 1'b0, 1'b0, 1'b0, 12'd4, 12'd8, 4'd0, 1'b1, 1'b1},
    '{4'd2, 1'b0, 1'b0, 1'b0, 12'd4, 12'd8, 4'd0, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive a command at the falling edge; settle so strobes can be sampled
  task automatic put(input logic [3:0] op);
    @(negedge clk);
    instr = op;
    #1;
  endtask

  // let the rising edge pass, then sample state mid-cycle
  task automatic edge_pass();
    @(posedge clk);
    #1;
  endtask

  task automatic setup(input int u0, input int u1, input int v0, input int v1,
                       input int w, input int h);
    put(4'h0);
    umin = 12'(u0); umax = 12'(u1); vmin = 12'(v0); vmax = 12'(v1);
    walk_w = 5'(w); walk_h = 5'(h);
    edge_pass();
    put(4'h1);
    edge_pass();
  endtask

  initial begin
    #1_000_000;
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int na, nc;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 done", done, 1);
    chk("R1 u", tgt_u, 0);
    chk("R1 v", tgt_v, 0);
    chk("R1 offs", {off_x, off_y}, 0);
    chk("R1 strobes", {accum, acc_clr, tgt_we}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // step before initialize is ignored (R8)
    put(4'h3);
    chk("R8 idle step", {accum, tgt_we}, 0);
    edge_pass();
    chk("R8 idle u", tgt_u, 0);

    // table run: R2 R3 R4 R5 R6 R7 R8 R9
    put(4'h0);
    umin = 12'd3; umax = 12'd4; vmin = 12'd7; vmax = 12'd8;
    walk_w = 5'd2; walk_h = 5'd1;
    edge_pass();
    for (int i = 0; i < NV; i++) begin
      put(TBL[i].op);
      chk($sformatf("R3 accum row%0d", i), accum, TBL[i].acc);
      chk($sformatf("R4 clr row%0d", i), acc_clr, TBL[i].clr);
      chk($sformatf("R5 we row%0d", i), tgt_we, TBL[i].we);
      edge_pass();
      chk($sformatf("R6 u row%0d", i), tgt_u, TBL[i].u);
      chk($sformatf("R6 v row%0d", i), tgt_v, TBL[i].v);
      chk($sformatf("R3 dx row%0d", i), off_x, TBL[i].dx);
      chk($sformatf("R7 eor row%0d", i), end_row, TBL[i].eor);
      chk($sformatf("R8 done row%0d", i), done, TBL[i].dn);
    end
    chk("R7 at_limit final", at_limit, 1);

    // R3 two-dimensional order, 3 wide by 2 high
    setup(10, 11, 0, 0, 3, 2);
    chk("R2 init u", tgt_u, 10);
    chk("R2 init done", done, 0);
    for (int i = 0; i < 6; i++) begin
      put(4'h3);
      chk("R3 2d accum", accum, 1);
      chk("R3 2d off_x", off_x, i % 3);
      chk("R3 2d off_y", off_y, i / 3);
      edge_pass();
    end
    put(4'h3);
    chk("R5 we after walk", tgt_we, 1);
    chk("R5 we no accum", accum, 0);
    chk("R5 we address", tgt_u, 10);
    edge_pass();
    chk("R6 u after write", tgt_u, 11);
    chk("R7 at_limit", at_limit, 1);

    // R3 largest neighbourhood 16x16
    setup(0, 1, 0, 1, 16, 16);
    na = 0; nc = 0;
    for (int i = 0; i < 256; i++) begin
      put(4'h3);
      na += int'(accum);
      nc += int'(acc_clr);
      edge_pass();
    end
    chk("R3 16x16 accum count", na, 256);
    chk("R4 16x16 clear count", nc, 1);
    put(4'h3);
    chk("R5 16x16 write", tgt_we, 1);
    edge_pass();

    // R11 single-point neighbourhood
    setup(0, 2, 5, 5, 1, 1);
    for (int p = 0; p < 3; p++) begin
      put(4'h3);
      chk("R11 acc+clr", {accum, acc_clr, tgt_we}, 3'b110);
      edge_pass();
      put(4'h3);
      chk("R11 write", {accum, tgt_we}, 2'b01);
      chk("R11 write u", tgt_u, p);
      edge_pass();
    end
    chk("R11 done", done, 1);

    // R10 next-line command
    setup(1, 5, 2, 3, 2, 2);
    put(4'h3); edge_pass();
    put(4'h3); edge_pass();
    put(4'h3); edge_pass();
    chk("R10 mid walk", {off_x, off_y}, {4'd1, 4'd1});
    put(4'h2);
    chk("R10 no strobes", {accum, tgt_we}, 0);
    edge_pass();
    chk("R10 u", tgt_u, 1);
    chk("R10 v", tgt_v, 3);
    chk("R10 offs", {off_x, off_y}, 0);
    chk("R10 not done", done, 0);
    put(4'h3);
    chk("R10 fresh walk clr", acc_clr, 1);
    edge_pass();
    put(4'h2); edge_pass();
    chk("R10 last line done", done, 1);
    chk("R10 v held", tgt_v, 3);
    put(4'h1); edge_pass();
    chk("R8 init clears done", done, 0);
    chk("R2 reinit v", tgt_v, 2);
    // R9 unused code holds
    put(4'hF);
    chk("R9 unused strobes", {accum, acc_clr, tgt_we}, 0);
    edge_pass();
    chk("R9 unused u", tgt_u, 1);

    put(4'h0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule